// File: doc/BRIEF.md
# Advanced-Mode Register File with Parameter Memory

This block is the register set that a floppy disk controller exposes while it runs in its advanced mode. A host access carries a byte address, a write flag and a data byte. The block takes the register slot from four address bits that sit above a fixed shift of nine. Slots 0 to 7 take writes and slots 8 to 15 return read data. The block holds four kinds of state:
- a mode register, written through one port that clears bits and another that sets them;
- a phase byte that can be read back;
- a sixteen-byte parameter memory, reached through one slot and an auto-incrementing pointer;
- a handshake value and a status value, both derived from other state.

The legacy side of the controller raises `enter_adv` to hand control to this block. The block then sets the advanced flag in bit 6 of the mode register. A mode-clear write that leaves bit 6 at 0 hands control back: the block drops `adv_active` and pulses `legacy_req` for one cycle, and the legacy side uses that pulse to clear its latches. The block ignores host accesses while `adv_active` is low.

Top module: `adv_regfile`

## Requirements
- R1: The slot is `acc_addr[12:9]`. Address bits below bit 9 have no effect. While `adv_active` is 0, an access changes no state and `rdata` is 0x00.
- R2: A write to slot 6 (mode-clear) clears each mode bit whose position is 1 in `wdata`.
- R3: A write to slot 7 (mode-set) sets each mode bit whose position is 1 in `wdata`.
- R4: A write to slot 6 resets the parameter pointer to 0.
- R5: When mode bit 6 is 0 after a mode-clear write, `adv_active` goes to 0 and `legacy_req` is 1 for exactly the following cycle.
- R6: A write to slot 3 stores `wdata` at the pointer. A read of slot 11 returns the byte at the pointer. Both advance the pointer by one, and it wraps from 15 to 0.
- R7: A write to slot 4 stores the phase byte, and a read of slot 12 returns it.
- R8: A read of slot 15 returns 0x08 when the phase byte is 0x77 and 0x00 for any other phase value.
- R9: A read of slot 14 returns `status_in` with bit 6 replaced by the `adv_active` flag.
- R10: While `adv_active` is 0, a pulse on `enter_adv` sets `adv_active` and mode bit 6. No other mode bit changes.
- R11: Writes to slots 0, 1, 2 and 5, and to any read slot, change no state. Reads of slots 0 to 10 other than 11, and of slot 13, return 0x00.
- R12: The synchronous active-low reset clears the mode register, the phase byte, the pointer, all sixteen parameter bytes and `adv_active`. It also clears `legacy_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_adv | input | 1 | One-cycle request from the legacy side to enter advanced mode |
| acc_en | input | 1 | Host access strobe, one access per cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 13 | Byte address of the access |
| wdata | input | 8 | Write data |
| status_in | input | 8 | Status bits supplied by the drive-side logic |
| rdata | output | 8 | Read data, valid in the same cycle as a read access |
| mode_bits | output | 8 | Current mode register |
| adv_active | output | 1 | 1 while advanced mode is active |
| legacy_req | output | 1 | One-cycle pulse asking the legacy side to take over and clear its latches |

## Verification
The hardest state to reach is the parameter pointer at an arbitrary offset, or just past its wrap, at the moment a mode-clear write arrives. Reaching it also needs the block to be re-entered after each exit. The stimulus mixes random slot, data and low-address traffic with random re-entries. As a result, parameter accesses build up pointer offsets across many exits, and mode-clear writes land at random points in that sequence. Directed steps add a full wrap of seventeen accesses, a mode-clear that keeps bit 6 set, and the handshake read with phase values on and next to the query value 0x77.

// File: rtl/adv_regfile_pkg.sv
// Shared definitions for the advanced-mode register file.
// Assumes eight-bit registers and a four-bit slot index.
package adv_regfile_pkg;
    localparam int SLOT_W = 4;

    typedef enum logic [SLOT_W-1:0] {
        SL_WR_DATA  = 4'd0,
        SL_WR_MARK  = 4'd1,
        SL_WR_CRC   = 4'd2,
        SL_WR_PARAM = 4'd3,
        SL_WR_PHASE = 4'd4,
        SL_WR_SETUP = 4'd5,
        SL_WR_MCLR  = 4'd6,
        SL_WR_MSET  = 4'd7,
        SL_RD_DATA  = 4'd8,
        SL_RD_MARK  = 4'd9,
        SL_RD_ERROR = 4'd10,
        SL_RD_PARAM = 4'd11,
        SL_RD_PHASE = 4'd12,
        SL_RD_SETUP = 4'd13,
        SL_RD_STAT  = 4'd14,
        SL_RD_HSHK  = 4'd15
    } slot_t;

    localparam int          ADV_BIT      = 6;
    localparam logic [7:0]  HS_SENSE     = 8'h08;
    localparam logic [7:0]  PHASE_QUERY  = 8'h77;
endpackage

// File: rtl/adv_slot_decode.sv
// Slot decoder: extracts the slot from the byte address and turns a host
// access into per-register strobes. Assumes one access per cycle and
// gates every strobe with the advanced-mode flag.
module adv_slot_decode
    import adv_regfile_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int SLOT_SHIFT = 9
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              active,
    output slot_t             slot,
    output logic              rd_en,
    output logic              wr_param,
    output logic              rd_param,
    output logic              wr_phase,
    output logic              wr_mclr,
    output logic              wr_mset
);
    logic live_wr;
    logic live_rd;

    // Slot extraction and strobe generation.
    always_comb begin
        slot     = slot_t'(acc_addr[SLOT_SHIFT +: SLOT_W]);
        live_wr  = acc_en && acc_wr && active;
        live_rd  = acc_en && !acc_wr && active;
        rd_en    = live_rd;
        wr_param = live_wr && (slot == SL_WR_PARAM);
        rd_param = live_rd && (slot == SL_RD_PARAM);
        wr_phase = live_wr && (slot == SL_WR_PHASE);
        wr_mclr  = live_wr && (slot == SL_WR_MCLR);
        wr_mset  = live_wr && (slot == SL_WR_MSET);
    end
endmodule

// File: rtl/adv_mode_ctrl.sv
// Mode register and mode state. Keeps the mode byte, which has separate
// clear and set ports, and the advanced-mode flag, and raises the
// return-to-legacy pulse. Assumes write strobes arrive only while active.
module adv_mode_ctrl
    import adv_regfile_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_adv,
    input  logic              wr_clr,
    input  logic              wr_set,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic              adv_q,
    output logic              leg_req_q
);
    localparam logic [DATA_W-1:0] ADV_MASK = DATA_W'(1) << ADV_BIT;

    logic [DATA_W-1:0] after_clr;

    // Value the mode byte takes if the current write is a mode-clear.
    always_comb after_clr = mode_q & ~wdata;

    // Mode byte, advanced flag and exit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            adv_q     <= 1'b0;
            leg_req_q <= 1'b0;
        end else begin
            leg_req_q <= 1'b0;
            if (enter_adv && !adv_q) begin
                mode_q <= mode_q | ADV_MASK;
                adv_q  <= 1'b1;
            end else if (wr_clr) begin
                mode_q <= after_clr;
                if (!after_clr[ADV_BIT]) begin
                    adv_q     <= 1'b0;
                    leg_req_q <= 1'b1;
                end
            end else if (wr_set) begin
                mode_q <= mode_q | wdata;
            end
        end
    end

    AST_ADV_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q |-> mode_q[ADV_BIT]);                                   // R10
    AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_adv && !adv_q) |=> (adv_q && mode_q[ADV_BIT]));        // R10
    AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        leg_req_q |-> (!adv_q && !mode_q[ADV_BIT]));                  // R5
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        leg_req_q |=> !leg_req_q);                                    // R5
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr && adv_q) |=> ((mode_q & $past(wdata)) == $past(wdata))); // R3
endmodule

// File: rtl/adv_param_ram.sv
// Parameter memory reached through one port with an auto-incrementing,
// wrapping pointer. A pointer clear overrides an access in the same
// cycle. Assumes a read and a write never arrive together.
module adv_param_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ptr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int               PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_inc;

    // Next pointer value after an access, wrapping at the last entry.
    always_comb ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

    // Read port: the byte at the pointer.
    always_comb rdata = mem_q[ptr_q];

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr_q <= '0;
        else if (ptr_clr)          ptr_q <= '0;
        else if (wr_en || rd_en)   ptr_q <= ptr_inc;
    end

    // One storage byte per entry, cleared on reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                                  mem_q[g] <= '0;
            else if (wr_en && ptr_q == PTR_W'(g))        mem_q[g] <= wdata;
        end
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (ptr_q == '0));                                   // R4
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !ptr_clr && ptr_q == LAST) |=> (ptr_q == '0)); // R6
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_clr) |=> (mem_q[$past(ptr_q)] == $past(wdata))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !ptr_clr) |=> $stable(ptr_q));           // R11
endmodule

// File: rtl/adv_regfile.sv
// Advanced-mode register file: decodes host accesses into sixteen slots
// and holds the mode, phase and parameter state. Reads are combinational
// in the access cycle, and their side effects take place at the clock edge.
// Assumes the legacy side raises enter_adv and reacts to legacy_req.
module adv_regfile
    import adv_regfile_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int SLOT_SHIFT = 9,
    parameter int DATA_W     = 8,
    parameter int PRAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_adv,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_bits,
    output logic              adv_active,
    output logic              legacy_req
);
    slot_t             slot;
    logic              rd_en, wr_param, rd_param, wr_phase, wr_mclr, wr_mset;
    logic [DATA_W-1:0] phase_q;
    logic [DATA_W-1:0] pram_rd;

    adv_slot_decode #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)) u_dec (
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .active(adv_active), .slot(slot), .rd_en(rd_en),
        .wr_param(wr_param), .rd_param(rd_param), .wr_phase(wr_phase),
        .wr_mclr(wr_mclr), .wr_mset(wr_mset)
    );

    adv_mode_ctrl #(.DATA_W(DATA_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .enter_adv(enter_adv),
        .wr_clr(wr_mclr), .wr_set(wr_mset), .wdata(wdata),
        .mode_q(mode_bits), .adv_q(adv_active), .leg_req_q(legacy_req)
    );

    adv_param_ram #(.DATA_W(DATA_W), .DEPTH(PRAM_DEPTH)) u_pram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_param), .rd_en(rd_param),
        .ptr_clr(wr_mclr), .wdata(wdata), .rdata(pram_rd)
    );

    // Phase byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (wr_phase) phase_q <= wdata;
    end

    // Read data selection for the read slots.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (slot)
                SL_RD_PARAM: rdata = pram_rd;
                SL_RD_PHASE: rdata = phase_q;
                SL_RD_STAT: begin
                    rdata          = status_in;
                    rdata[ADV_BIT] = adv_active;
                end
                SL_RD_HSHK:  rdata = (phase_q == PHASE_QUERY) ? HS_SENSE : '0;
                default:     rdata = '0;
            endcase
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_active |-> (rdata == '0));                               // R1
    AST_PHASE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && adv_active && slot == SL_WR_PHASE) |=>
        (phase_q == $past(wdata)));                                   // R7
    AST_HS_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && slot == SL_RD_HSHK) |-> (rdata == '0 || rdata == HS_SENSE)); // R8
endmodule

// File: tb/adv_regfile_tb_top.sv
`timescale 1ns/1ps
module adv_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_adv = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [12:0] acc_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  rdata, mode_bits;
    logic        adv_active, legacy_req;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [7:0] m_mem [16];
    logic [3:0] m_ptr;
    logic [7:0] m_phase, m_mode;
    logic       m_adv, m_leg;

    always #2 clk = ~clk;

    adv_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .enter_adv(enter_adv), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .wdata(wdata),
        .status_in(status_in), .rdata(rdata), .mode_bits(mode_bits),
        .adv_active(adv_active), .legacy_req(legacy_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic string req_of_read(input logic [3:0] s);
        case (s)
            4'd11: return "R6";
            4'd12: return "R7";
            4'd14: return "R9";
            4'd15: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] s);
        if (!m_adv) return 8'h00;
        case (s)
            4'd11: return m_mem[m_ptr];
            4'd12: return m_phase;
            4'd14: return {status_in[7], m_adv, status_in[5:0]};
            4'd15: return (m_phase == 8'h77) ? 8'h08 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
        m_ptr = 0; m_phase = 0; m_mode = 0; m_adv = 0; m_leg = 0;
    endtask

    task automatic check_state();
        check("R2/R3 mode", mode_bits, m_mode);
        check("R5/R10 adv", {7'd0, adv_active}, {7'd0, m_adv});
        check("R5 legacy_req", {7'd0, legacy_req}, {7'd0, m_leg});
    endtask

    // One host access. The read data is checked before the edge and the state after it.
    task automatic op(input logic wr, input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; wdata = d;
        acc_addr = {s, 9'($urandom)};
        status_in = 8'($urandom);
        #1;
        if (!wr) check(m_adv ? req_of_read(s) : "R1", rdata, exp_read(s));
        @(posedge clk); #1;
        acc_en = 1'b0;
        m_leg = 1'b0;
        if (m_adv) begin
            if (wr) begin
                case (s)
                    4'd3: begin m_mem[m_ptr] = d; m_ptr++; end
                    4'd4: m_phase = d;
                    4'd6: begin
                        m_mode = m_mode & ~d; m_ptr = 0;
                        if (!m_mode[6]) begin m_adv = 0; m_leg = 1; end
                    end
                    4'd7: m_mode = m_mode | d;
                    default: ;
                endcase
            end else if (s == 4'd11) m_ptr++;
        end
        check_state();
    endtask

    task automatic enter();
        @(negedge clk); enter_adv = 1'b1;
        @(posedge clk); #1; enter_adv = 1'b0;
        if (!m_adv) begin m_adv = 1; m_mode[6] = 1'b1; end
        m_leg = 0;
        check_state();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset state
        check("R12 mode", mode_bits, 8'h00);
        check("R12 adv", {7'd0, adv_active}, 8'h00);
        check("R12 legacy_req", {7'd0, legacy_req}, 8'h00);
        // R1: inactive block ignores accesses
        op(1'b1, 4'd4, 8'h77);
        op(1'b0, 4'd15, 8'h00);
        op(1'b1, 4'd7, 8'hff);
        enter();                            // R10
        op(1'b0, 4'd12, 8'h00);             // R12 phase cleared, R1 write ignored
        for (int i = 0; i < 16; i++) op(1'b0, 4'd11, 8'h00); // R12 memory cleared
        // R6 full wrap: 16 writes then 17 reads
        for (int i = 0; i < 16; i++) op(1'b1, 4'd3, 8'(8'h30 + i));
        for (int i = 0; i < 17; i++) op(1'b0, 4'd11, 8'h00);
        // R4 pointer reset via mode-clear keeping bit 6; R2
        op(1'b1, 4'd7, 8'h9b);              // R3
        op(1'b0, 4'd11, 8'h00);
        op(1'b1, 4'd6, 8'h13);              // R2, R4
        op(1'b0, 4'd11, 8'h00);
        // R8 handshake around the query value
        op(1'b1, 4'd4, 8'h77); op(1'b0, 4'd15, 8'h00); op(1'b0, 4'd12, 8'h00);
        op(1'b1, 4'd4, 8'h76); op(1'b0, 4'd15, 8'h00);
        op(1'b1, 4'd4, 8'hf7); op(1'b0, 4'd15, 8'h00);
        // R11 ignored slots
        op(1'b1, 4'd0, 8'haa); op(1'b1, 4'd5, 8'h55); op(1'b1, 4'd12, 8'h11);
        op(1'b0, 4'd13, 8'h00); op(1'b0, 4'd2, 8'h00); op(1'b0, 4'd12, 8'h00);
        op(1'b0, 4'd14, 8'h00);             // R9
        // R5 exit
        op(1'b1, 4'd6, 8'h40);
        op(1'b0, 4'd14, 8'h00);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            if (!m_adv && ($urandom % 4) != 0) enter();
            else op(1'($urandom), 4'($urandom), ($urandom % 3 == 0) ? 8'h77 : 8'($urandom));
        end
        // R12: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        model_reset();
        check_state();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule